// File: doc/BRIEF.md
# PIO Read Command Sequencer (host side)

This block runs one device-to-host programmed-I/O read command on a parallel disk task-file interface, seen from the host. A client pulses `start_i` together with the opcode and the parameter bytes. The sequencer polls the status register until the device is free and ready. It writes the parameter registers and then the command register. It then moves data one sector per interrupt: on each interrupt it reads status first, and then reads the 16-bit data register once for each word of the sector. Every word it reads appears on a one-cycle-valid word stream.

The command ends with a single-cycle `done_o`. `err_o` is raised in that same cycle when the device reported an error, when a wait timed out, or when the status read returned no data request for a data command. Two opcodes are exempt from the ready check and carry no data phase. READ LONG adds extra words to each sector. Physical strobe timing and DMA are outside this block.

Top module: `pio_rd_seq`

## Requirements
- R1: No task-file write takes place while the last status value read had busy (bit 7) set. Status (address 7) is read once per cycle until busy clears.
- R2: The command is held back while ready (bit 6) is 0, except for opcodes 0x90 and 0x91, which are issued regardless of ready.
- R3: Parameter writes go to addresses 1 (features), 2 (count), 3 (sector), 4 (cylinder low byte), 5 (cylinder high byte) and 6 (device/head), in that order, on data bits 7:0. They are followed by exactly one write of the opcode to address 7.
- R4: After each rising edge of `intrq_i`, status (address 7) is read before any data-register (address 0) read.
- R5: Each sector is SECTOR_WORDS data reads. For opcode 0x22 it is SECTOR_WORDS+LONG_EXTRA_WORDS reads. Each word is presented on `word_data_o` with `word_valid_o` high in the cycle after its read.
- R6: A sector count of N sectors (1 to 255) moves N sectors, one per interrupt. A count of 0 moves 256 sectors.
- R7: If a status read shows data request (bit 3) together with error (bit 0), that sector is still drained and the command then ends with `err_o`. If error is set without data request, the command ends with `err_o` and no data read.
- R8: If busy or not-ready persists for TIMEOUT_CYC cycles of polling, or no interrupt arrives within TIMEOUT_CYC cycles, the command ends with `err_o`.
- R9: `start_i` is ignored while `busy_o` is high. `done_o` is a single pulse, and `busy_o` is low while it is high.
- R10: Opcodes 0x90 and 0x91 end at the status read that follows their interrupt, with no data reads. `err_o` follows the error bit of that read.
- R11: After reset `busy_o`, `done_o`, `err_o`, `word_valid_o`, `tf_wr_o` and `tf_rd_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a command (taken only when idle) |
| opcode_i | input | 8 | Command opcode |
| features_i | input | 8 | Features byte |
| count_i | input | 8 | Sector count (0 means 256) |
| sector_i | input | 8 | Sector number |
| cylinder_i | input | 16 | Cylinder |
| devhead_i | input | 8 | Device/head byte |
| busy_o | output | 1 | Command in progress |
| tf_addr_o | output | 3 | Task-file register address |
| tf_wr_o | output | 1 | Task-file write strobe |
| tf_rd_o | output | 1 | Task-file read strobe |
| tf_wdata_o | output | 16 | Task-file write data |
| tf_rdata_i | input | 16 | Task-file read data, valid in the cycle of the read |
| intrq_i | input | 1 | Device interrupt line |
| word_valid_o | output | 1 | Word stream valid |
| word_data_o | output | 16 | Word read from the data register |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 1 | Command finished with an error (with done_o) |

## Verification
A wrong sector or word counter shows at the ports within one sector. It appears as a short or long word stream, as a repeated interrupt wait, or as wrong data tags, and the bench compares each word against its sector and word index. A wrong state after an interrupt shows as a data read with no status read in front of it. The bench flags that in the same cycle, and a write sent while busy is flagged the same way. Stuck waits surface as the timeout error after TIMEOUT_CYC cycles, so no hang lasts longer than that.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;
  localparam logic [2:0] TF_DATA    = 3'd0;
  localparam logic [2:0] TF_DEVHEAD = 3'd6;
  localparam logic [2:0] TF_CMDSTAT = 3'd7;

  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  localparam logic [7:0] OP_READ_LONG = 8'h22;
  localparam logic [7:0] OP_DIAG      = 8'h90;
  localparam logic [7:0] OP_INIT_PARM = 8'h91;

  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_PARAM, S_CMD, S_WAIT, S_STAT, S_DATA
  } seq_state_e;
endpackage

// File: rtl/pio_rd_op_decode.sv
module pio_rd_op_decode
  import pio_rd_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       exempt_o,
  output logic       long_o
);
  assign exempt_o = (op_i == OP_DIAG) || (op_i == OP_INIT_PARM);
  assign long_o   = (op_i == OP_READ_LONG);
endmodule

// File: rtl/pio_rd_timer.sv
module pio_rd_timer #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = en_i && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (en_i && !expired_o)    cnt_q <= cnt_q + 1'b1;
  end

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |=> cnt_q != '0 || $past(expired_o));
endmodule

// File: rtl/pio_rd_xfer_ctr.sv
module pio_rd_xfer_ctr #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        count_i,
  input  logic [WORD_W-1:0] words_i,
  input  logic              step_i,
  output logic              last_word_o,
  output logic              last_sector_o
);
  logic [8:0]        sect_q;
  logic [WORD_W-1:0] word_q, lim_q;

  assign last_word_o   = (word_q == lim_q - 1'b1);
  assign last_sector_o = (sect_q == 9'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sect_q <= '0;
      word_q <= '0;
      lim_q  <= '0;
    end else if (load_i) begin
      sect_q <= (count_i == 8'd0) ? 9'd256 : {1'b0, count_i};
      word_q <= '0;
      lim_q  <= words_i;
    end else if (step_i) begin
      if (last_word_o) begin
        word_q <= '0;
        sect_q <= sect_q - 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

  p_step_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> sect_q != 9'd0);
endmodule

// File: rtl/pio_rd_seq.sv
module pio_rd_seq
  import pio_rd_pkg::*;
#(
  parameter int SECTOR_WORDS     = 256,
  parameter int LONG_EXTRA_WORDS = 2,
  parameter int TIMEOUT_CYC      = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  opcode_i,
  input  logic [7:0]  features_i,
  input  logic [7:0]  count_i,
  input  logic [7:0]  sector_i,
  input  logic [15:0] cylinder_i,
  input  logic [7:0]  devhead_i,
  output logic        busy_o,
  output logic [2:0]  tf_addr_o,
  output logic        tf_wr_o,
  output logic        tf_rd_o,
  output logic [15:0] tf_wdata_o,
  input  logic [15:0] tf_rdata_i,
  input  logic        intrq_i,
  output logic        word_valid_o,
  output logic [15:0] word_data_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int WORD_W = $clog2(SECTOR_WORDS + LONG_EXTRA_WORDS + 1);

  seq_state_e state_q, state_d;
  logic [2:0]  pidx_q;
  logic [7:0]  op_q, feat_q, cnt_q, sect_q, dh_q;
  logic [15:0] cyl_q;
  logic        err_pend_q, rdy_ok_q;
  logic        exempt, is_long, expired, last_word, last_sector;
  logic        fin, fin_err;
  logic [7:0]  pbyte;
  logic [7:0]  st;

  assign st = tf_rdata_i[7:0];

  pio_rd_op_decode u_dec (.op_i(op_q), .exempt_o(exempt), .long_o(is_long));

  pio_rd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .clr_i    (state_d != state_q),
    .en_i     (state_q == S_POLL || state_q == S_WAIT),
    .expired_o(expired)
  );

  pio_rd_xfer_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk_i, .rst_ni,
    .load_i       (state_q == S_CMD),
    .count_i      (cnt_q),
    .words_i      (is_long ? WORD_W'(SECTOR_WORDS + LONG_EXTRA_WORDS)
                           : WORD_W'(SECTOR_WORDS)),
    .step_i       (state_q == S_DATA),
    .last_word_o  (last_word),
    .last_sector_o(last_sector)
  );

  always_comb begin
    case (pidx_q)
      3'd0:    pbyte = feat_q;
      3'd1:    pbyte = cnt_q;
      3'd2:    pbyte = sect_q;
      3'd3:    pbyte = cyl_q[7:0];
      3'd4:    pbyte = cyl_q[15:8];
      default: pbyte = dh_q;
    endcase
  end

  always_comb begin
    tf_addr_o  = TF_DATA;
    tf_wr_o    = 1'b0;
    tf_rd_o    = 1'b0;
    tf_wdata_o = '0;
    case (state_q)
      S_POLL, S_STAT: begin tf_rd_o = 1'b1; tf_addr_o = TF_CMDSTAT; end
      S_PARAM: begin
        tf_wr_o = 1'b1; tf_addr_o = pidx_q + 3'd1; tf_wdata_o = {8'h00, pbyte};
      end
      S_CMD: begin tf_wr_o = 1'b1; tf_addr_o = TF_CMDSTAT; tf_wdata_o = {8'h00, op_q}; end
      S_DATA: tf_rd_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    fin_err = 1'b0;
    case (state_q)
      S_IDLE:  if (start_i) state_d = S_POLL;
      S_POLL:
        if (!st[ST_BSY] && (st[ST_DRDY] || exempt)) state_d = S_PARAM;
        else if (expired) begin fin = 1'b1; fin_err = 1'b1; end
      S_PARAM: if (pidx_q == 3'd5) state_d = S_CMD;
      S_CMD:   state_d = S_WAIT;
      S_WAIT:
        if (intrq_i) state_d = S_STAT;
        else if (expired) begin fin = 1'b1; fin_err = 1'b1; end
      S_STAT:
        if (exempt) begin fin = 1'b1; fin_err = st[ST_ERR]; end
        else if (st[ST_DRQ] && !st[ST_BSY]) state_d = S_DATA;
        else begin fin = 1'b1; fin_err = 1'b1; end
      S_DATA:
        if (last_word) begin
          if (err_pend_q) begin fin = 1'b1; fin_err = 1'b1; end
          else if (last_sector) fin = 1'b1;
          else state_d = S_WAIT;
        end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pidx_q <= '0;
      {op_q, feat_q, cnt_q, sect_q, dh_q, cyl_q} <= '0;
      err_pend_q <= 1'b0;
      rdy_ok_q <= 1'b0;
      done_o <= 1'b0;
      err_o <= 1'b0;
      word_valid_o <= 1'b0;
      word_data_o <= '0;
    end else begin
      state_q      <= state_d;
      done_o       <= fin;
      err_o        <= fin_err;
      word_valid_o <= (state_q == S_DATA);
      if (state_q == S_DATA) word_data_o <= tf_rdata_i;
      if (state_q == S_IDLE && start_i) begin
        op_q <= opcode_i; feat_q <= features_i; cnt_q <= count_i;
        sect_q <= sector_i; cyl_q <= cylinder_i; dh_q <= devhead_i;
        pidx_q <= '0;
        err_pend_q <= 1'b0;
        rdy_ok_q <= 1'b0;
      end
      if (state_q == S_POLL && state_d == S_PARAM) rdy_ok_q <= 1'b1;
      if (state_q == S_PARAM) pidx_q <= pidx_q + 3'd1;
      if (state_q == S_STAT) err_pend_q <= st[ST_ERR];
    end
  end

  assign busy_o = (state_q != S_IDLE);

  p_issue_after_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_wr_o |-> rdy_ok_q);
  p_cmd_after_devhead_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_wr_o && tf_addr_o == TF_CMDSTAT |-> $past(tf_wr_o && tf_addr_o == TF_DEVHEAD));
  p_stat_before_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tf_rd_o && tf_addr_o == TF_DATA && !$past(tf_rd_o && tf_addr_o == TF_DATA)
    |-> $past(tf_rd_o && tf_addr_o == TF_CMDSTAT));
  p_word_from_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(tf_rd_o && tf_addr_o == TF_DATA));
  p_err_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o ##1 !done_o);
  p_one_strobe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tf_wr_o && tf_rd_o));
endmodule

// File: tb/sim_pio_rd_seq.sv
`timescale 1ns/1ps
module sim_pio_rd_seq;
  localparam int SW = 8, LX = 2, TO = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] op = '0, feat = '0, cnt = '0, sec = '0, dh = '0;
  logic [15:0] cyl = '0;
  logic busy, tf_wr, tf_rd, intrq, wv, done, err;
  logic [2:0] tf_addr;
  logic [15:0] tf_wdata, tf_rdata, wdata;

  always #2.5 clk = ~clk;

  pio_rd_seq #(.SECTOR_WORDS(SW), .LONG_EXTRA_WORDS(LX), .TIMEOUT_CYC(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(op), .features_i(feat),
    .count_i(cnt), .sector_i(sec), .cylinder_i(cyl), .devhead_i(dh), .busy_o(busy),
    .tf_addr_o(tf_addr), .tf_wr_o(tf_wr), .tf_rd_o(tf_rd), .tf_wdata_o(tf_wdata),
    .tf_rdata_i(tf_rdata), .intrq_i(intrq), .word_valid_o(wv), .word_data_o(wdata),
    .done_o(done), .err_o(err));

  // device model configuration (driven by tasks)
  logic m_clr = 1'b0;
  bit   cfg_drdy, cfg_nodrq, cfg_hang;
  int   cfg_prebsy, cfg_errsec, cfg_wps = SW, cfg_cnt;

  // device model state
  int   pre_left, m_delay, m_left, m_sec, m_widx;
  bit   m_bsy, m_drq, m_err, m_irq, m_nod;
  logic [7:0] stat;

  assign intrq = m_irq;
  assign stat  = {(pre_left > 0) || m_bsy, cfg_drdy, 2'b00, m_drq, 2'b00, m_err};
  assign tf_rdata = (tf_addr == 3'd7) ? {8'h00, stat} :
                    (tf_addr == 3'd0) ? {8'(m_sec), 8'(m_widx)} : 16'h0;

  always @(posedge clk) begin
    if (m_clr) begin
      pre_left <= cfg_prebsy; m_delay <= 0; m_left <= 0; m_sec <= 0; m_widx <= 0;
      m_bsy <= 0; m_drq <= 0; m_err <= 0; m_irq <= 0; m_nod <= 0;
    end else begin
      if (tf_rd && tf_addr == 3'd7) begin
        m_irq <= 0;
        if (pre_left > 0) pre_left <= pre_left - 1;
      end
      if (tf_wr && tf_addr == 3'd7) begin
        m_bsy <= 1; m_delay <= 5; m_left <= (cfg_cnt == 0) ? 256 : cfg_cnt;
        m_sec <= 0; m_widx <= 0;
        m_nod <= (tf_wdata[7:0] == 8'h90) || (tf_wdata[7:0] == 8'h91);
      end else if (m_bsy) begin
        if (m_delay != 0) m_delay <= m_delay - 1;
        else if (!cfg_hang) begin
          m_bsy <= 0; m_irq <= 1;
          if (m_nod)          begin m_drq <= 0; m_err <= 0; end
          else if (cfg_nodrq) begin m_drq <= 0; m_err <= 1; end
          else begin m_drq <= 1; m_err <= (m_sec == cfg_errsec); end
        end
      end
      if (tf_rd && tf_addr == 3'd0) begin
        if (m_widx == cfg_wps - 1) begin
          m_widx <= 0; m_drq <= 0; m_sec <= m_sec + 1;
          if (m_left > 1) begin m_left <= m_left - 1; m_bsy <= 1; m_delay <= 3; end
          else m_left <= 0;
        end else m_widx <= m_widx + 1;
      end
    end
  end

  // monitors
  int n_wr, n_words, n_bad_word, n_r1_bad, n_r4_bad;
  logic [10:0] wlog [0:15];
  bit need_stat, irq_prev;
  always @(negedge clk) begin
    if (m_clr) begin
      n_wr = 0; n_words = 0; n_bad_word = 0; n_r1_bad = 0; n_r4_bad = 0;
      need_stat = 0; irq_prev = 0;
    end else begin
      if (tf_wr) begin
        if (n_wr < 16) wlog[n_wr] = {tf_addr, tf_wdata[7:0]};
        n_wr++;
        if (pre_left > 0) n_r1_bad++;
      end
      if (wv) begin
        if (wdata != {8'(n_words / cfg_wps), 8'(n_words % cfg_wps)}) n_bad_word++;
        n_words++;
      end
      if (intrq && !irq_prev) need_stat = 1;
      if (tf_rd && tf_addr == 3'd7) need_stat = 0;
      if (tf_rd && tf_addr == 3'd0 && need_stat) n_r4_bad++;
      irq_prev = intrq;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] o, input logic [7:0] f, input logic [7:0] c,
                     input bit drdy, input int prebsy, input int errsec,
                     input bit nodrq, input bit hang, input bit mid_start);
    int sectors, wps, exp_words, exp_wr, cyc;
    bit nod, exp_err, got_err, got_done;
    logic [10:0] exp_log [0:6];
    sectors = (c == 0) ? 256 : int'(c);
    wps = (o == 8'h22) ? SW + LX : SW;
    nod = (o == 8'h90) || (o == 8'h91);
    exp_wr = 7; exp_words = 0; exp_err = 0;
    if (!drdy && !nod)    begin exp_err = 1; exp_wr = 0; end
    else if (hang)          exp_err = 1;
    else if (nod)           exp_err = 0;
    else if (nodrq)         exp_err = 1;
    else if (errsec < sectors) begin exp_err = 1; exp_words = (errsec + 1) * wps; end
    else exp_words = sectors * wps;
    sec = 8'h3C ^ c; cyl = {c, 8'hA5}; dh = 8'hE0 | 8'(c & 8'h0F);
    exp_log[0] = {3'd1, f}; exp_log[1] = {3'd2, c}; exp_log[2] = {3'd3, sec};
    exp_log[3] = {3'd4, cyl[7:0]}; exp_log[4] = {3'd5, cyl[15:8]};
    exp_log[5] = {3'd6, dh}; exp_log[6] = {3'd7, o};

    cfg_drdy = drdy; cfg_prebsy = prebsy; cfg_errsec = errsec; cfg_nodrq = nodrq;
    cfg_hang = hang; cfg_wps = wps; cfg_cnt = int'(c);
    m_clr = 1;
    @(posedge clk); @(negedge clk); #1 m_clr = 0;
    op = o; feat = f; cnt = c; start = 1;
    @(negedge clk); start = 0;
    got_done = 0; got_err = 0;
    for (cyc = 0; cyc < 20000; cyc++) begin
      if (mid_start && cyc == 15) begin op = 8'hEC; start = 1; end
      else start = 0;
      @(negedge clk);
      if (done) begin got_done = 1; got_err = err; break; end
    end
    start = 0;
    @(negedge clk);
    chk(got_done, "R9", "done seen", int'(got_done), 1);
    chk(got_err == exp_err, "R7/R8", "err flag", int'(got_err), int'(exp_err));
    chk(n_words == exp_words, "R5/R6", "word count", n_words, exp_words);
    chk(n_bad_word == 0, "R5", "bad word tags", n_bad_word, 0);
    chk(n_wr == exp_wr, "R3/R9", "write count", n_wr, exp_wr);
    chk(n_r1_bad == 0, "R1", "writes while busy", n_r1_bad, 0);
    chk(n_r4_bad == 0, "R4", "data before status", n_r4_bad, 0);
    if (exp_wr == 7 && n_wr == 7)
      for (int i = 0; i < 7; i++)
        chk(wlog[i] == exp_log[i], "R3", "write order", int'(wlog[i]), int'(exp_log[i]));
    chk(!busy && !done, "R9", "idle after done", int'(busy), 0);
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cfg_prebsy = 0; cfg_drdy = 1; cfg_errsec = 999; cfg_nodrq = 0; cfg_hang = 0; cfg_cnt = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !err && !wv && !tf_wr && !tf_rd, "R11", "reset outputs",
        int'({busy, done, err, wv, tf_wr, tf_rd}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tf_wr && !tf_rd, "R11", "idle after reset", int'({busy, tf_wr, tf_rd}), 0);

    // R5 R6 R1: sweep normal and long reads over small counts, with busy polls
    for (int c = 1; c <= 5; c++) begin
      run(8'h20, 8'h00, 8'(c), 1, c, 999, 0, 0, 0);
      run(8'h22, 8'h11, 8'(c), 1, 2, 999, 0, 0, 0);
    end
    // R6: count 0 means 256 sectors
    run(8'h20, 8'h00, 8'h00, 1, 0, 999, 0, 0, 0);
    // R2 R8: not ready blocks a normal read until timeout
    run(8'h20, 8'h00, 8'h02, 0, 0, 999, 0, 0, 0);
    // R2 R10: exempt opcodes issue without ready and have no data phase
    run(8'h90, 8'h00, 8'h01, 0, 3, 999, 0, 0, 0);
    run(8'h91, 8'h07, 8'h01, 0, 0, 999, 0, 0, 0);
    // R7: error with DRQ drains that sector then stops
    run(8'h20, 8'h00, 8'h04, 1, 0, 1, 0, 0, 0);
    run(8'hEC, 8'h00, 8'h01, 1, 0, 0, 0, 0, 0);
    // R7: error without DRQ
    run(8'hE4, 8'h00, 8'h01, 1, 0, 999, 1, 0, 0);
    // R8: interrupt never arrives
    run(8'h20, 8'h00, 8'h01, 1, 0, 999, 0, 1, 0);
    // R9: start while busy is ignored
    run(8'h20, 8'h00, 8'h03, 1, 1, 999, 0, 0, 1);
    // smart read with features subcode
    run(8'hB0, 8'hD0, 8'h01, 1, 0, 999, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule